// File: doc/BRIEF.md
# Byte-Addressed Register Target for a Two-Wire Serial Bus

This block is an I2C target that lets a bus controller read and write a 256-entry byte register space. SCL and SDA are sampled on a faster system clock and pass through a synchronizer. The block then finds the clock edges and the START, repeated START and STOP conditions. It compares the incoming 7-bit device address with the `dev_addr` input and drives SDA low, through an open-drain enable, to acknowledge a match.

The first byte of a write transaction loads an internal register pointer. Each later data byte in the same transaction is written through the register-file port at the pointer, and the pointer then advances. A read transaction returns bytes starting at the pointer and advances it for each byte it loads.

The pointer keeps its value across STOP, so a read that follows with no address phase continues where the last access ended. The pointer wraps from 0xFF to 0x00. The register file sits outside the block and answers combinationally on `reg_rdata` for the address on `reg_addr`.

Top module: `i2c_regport_target`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are low and the register pointer is 0x00, so a first read with no address phase returns register 0x00.
- R2: A START (SDA falling while SCL is high) begins an address byte, shifted MSB first. The upper 7 bits are the device address and bit 0 selects the direction, with 0 meaning write and 1 meaning read. When the address equals `dev_addr`, the block drives SDA low during the ninth SCL pulse.
- R3: When the address does not match, the block leaves SDA released in the ninth pulse. It drives nothing and writes nothing until the next START.
- R4: In a write transaction, the first byte after the address loads the register pointer and is acknowledged.
- R5: Each further byte of a write transaction produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments, and the byte is acknowledged.
- R6: In a read transaction, the block drives the register at the pointer MSB first, changing SDA only while SCL is low, and increments the pointer for each byte it loads.
- R7: When the controller acknowledges a read byte, the next sequential register follows. A not-acknowledge ends the burst: SDA stays released and the pointer does not advance again.
- R8: The pointer wraps from 0xFF to 0x00, in write bursts and read bursts alike.
- R9: A STOP (SDA rising while SCL is high) leaves the pointer unchanged, so a later read with no address phase continues from it.
- R10: A repeated START in the middle of a transaction begins a new address byte, so a pointer write followed by a repeated START and a read returns data from the new pointer.
- R11: With a 50 MHz system clock, the block works at SCL rates of both 100 kbit/s and 400 kbit/s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Device address this target answers to |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls SDA low when high (open-drain enable) |
| reg_addr | output | 8 | Register-file address (the current pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write strobe, one cycle per byte |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
At the SCL falling edge that ends a data byte, the write strobe and the pointer increment fall in the same system-clock cycle. At the edge that starts each read byte, the register fetch and the pointer increment fall in the same cycle. A burst write starting at 0xFE and a burst read across the same boundary put the pointer wrap into that shared cycle. Each is judged by reading registers 0xFE, 0xFF, 0x00 and 0x01 back over the bus and by counting write strobes. A repeated START arriving right after a pointer-load acknowledge is also driven, to confirm that the restart wins over the pending data phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int DEVA_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus free or not yet addressed
    ST_RECV,   // shifting a byte in from the controller
    ST_RACK,   // target drives acknowledge
    ST_SEND,   // shifting a register byte out
    ST_MACK,   // controller acknowledge slot after a sent byte
    ST_WAIT    // silent until START or STOP
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_DEV,    // byte holds device address and direction
    PH_PTR,    // byte loads the register pointer
    PH_DATA    // byte is written to the register file
  } rx_phase_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic [STAGES-1:0] scl_pipe_n, sda_pipe_n;
  logic              scl_d, sda_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign scl_pipe_n = {scl_pipe[STAGES-2:0], scl_i};
      assign sda_pipe_n = {sda_pipe[STAGES-2:0], sda_i};
    end else begin : g_single
      assign scl_pipe_n = scl_i;
      assign sda_pipe_n = sda_i;
    end
  endgenerate

  // Idle bus reads high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_d    <= scl_lvl;
      sda_d    <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign bus_start = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_tgt_shreg.sv
module i2c_tgt_shreg #(
  parameter  int W  = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic          cap,
  input  logic          sh,
  input  logic          in_bit,
  input  logic [W-1:0]  ld_val,
  output logic [W-1:0]  data,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  data_q, data_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    data_n = data_q;
    cnt_n  = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (ld) begin
      data_n = ld_val;
      cnt_n  = '0;
    end else if (cap) begin
      data_n = {data_q[W-2:0], in_bit};
      cnt_n  = cnt_q + CW'(1);
    end else if (sh) begin
      data_n = {data_q[W-2:0], 1'b1};
      cnt_n  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '1;
      cnt_q  <= '0;
    end else if (clr | ld | cap | sh) begin
      data_q <= data_n;
      cnt_q  <= cnt_n;
    end
  end

  assign data = data_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] ptr
);
  logic [W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (load)      ptr_n = load_val;
    else if (step) ptr_n = ptr_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ptr_q <= '0;
    else if (load | step) ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;

  // R9: pointer only moves on a load or a step, never on STOP alone
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(ptr_q));

  // R8: stepping past the top address lands on zero
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr_q == '1) |=> (ptr_q == '0));
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEVA_W-1:0] dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  logic              sr_clr, sr_ld, sr_cap, sr_sh;
  logic [BYTE_W-1:0] sr_data;
  logic [CW-1:0]     sr_cnt;

  i2c_tgt_shreg #(.W(BYTE_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .clr(sr_clr), .ld(sr_ld), .cap(sr_cap),
    .sh(sr_sh), .in_bit(sda_lvl), .ld_val(reg_rdata),
    .data(sr_data), .cnt(sr_cnt)
  );

  logic              ptr_load, ptr_step;
  logic [BYTE_W-1:0] ptr;

  i2c_tgt_ptr #(.W(BYTE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(sr_data),
    .step(ptr_step), .ptr(ptr)
  );

  tgt_state_e st_q, st_n;
  rx_phase_e  ph_q, ph_n;
  logic       rw_q, rw_n;
  logic       mack_q, mack_n;
  logic       we_n;

  // Next-state logic; START and STOP override every state.
  always_comb begin
    st_n     = st_q;
    ph_n     = ph_q;
    rw_n     = rw_q;
    mack_n   = mack_q;
    sr_clr   = 1'b0;
    sr_ld    = 1'b0;
    sr_cap   = 1'b0;
    sr_sh    = 1'b0;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    we_n     = 1'b0;
    if (bus_start) begin
      st_n   = ST_RECV;
      ph_n   = PH_DEV;
      sr_clr = 1'b1;
    end else if (bus_stop) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_RECV: begin
          if (scl_rise && sr_cnt != CNT_FULL) sr_cap = 1'b1;
          if (scl_fall && sr_cnt == CNT_FULL) begin
            unique case (ph_q)
              PH_DEV: begin
                if (sr_data[BYTE_W-1:1] == dev_addr) begin
                  rw_n = sr_data[0];
                  st_n = ST_RACK;
                end else begin
                  st_n = ST_WAIT;
                end
              end
              PH_PTR: begin
                ptr_load = 1'b1;
                st_n     = ST_RACK;
              end
              default: begin
                we_n     = 1'b1;
                ptr_step = 1'b1;
                st_n     = ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            if (ph_q == PH_DEV && rw_q) begin
              sr_ld    = 1'b1;
              ptr_step = 1'b1;
              st_n     = ST_SEND;
            end else begin
              sr_clr = 1'b1;
              st_n   = ST_RECV;
              ph_n   = (ph_q == PH_DEV) ? PH_PTR : PH_DATA;
            end
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (sr_cnt == CNT_LAST) st_n  = ST_MACK;
            else                    sr_sh = 1'b1;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_n = ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              sr_ld    = 1'b1;
              ptr_step = 1'b1;
              st_n     = ST_SEND;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_DEV;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      rw_q   <= rw_n;
      mack_q <= mack_n;
    end
  end

  // Write strobe is combinational so it meets reg_addr before the step.
  assign reg_we    = we_n;
  assign reg_addr  = ptr;
  assign reg_wdata = sr_data;
  assign sda_oe    = (st_q == ST_RACK) | ((st_q == ST_SEND) & ~sr_data[BYTE_W-1]);

  // R5: one strobe per byte
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5: a written byte is acknowledged right after its strobe
  p_we_then_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> sda_oe);

  // R6: the target only moves SDA while SCL is low
  p_sda_edge_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));
endmodule

// File: tb/i2c_regport_target_tb.sv
module i2c_regport_target_tb_top;
  localparam logic [6:0] DEV   = 7'h3A;
  localparam logic [6:0] OTHER = 7'h3B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;
  logic [7:0] mem [256];
  int         we_cnt = 0, oe_cnt = 0;
  int         n_chk = 0, n_err = 0, q_cyc = 31;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_line  = ~(m_sda_low | sda_oe);
  assign reg_rdata = mem[reg_addr];

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i[7:0]);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  always @(posedge clk) begin
    if (reg_we) we_cnt <= we_cnt + 1;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  i2c_regport_target dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (q_cyc) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; qwait();
    m_scl = 1'b1;     qwait();
    m_sda_low = 1'b1; qwait();
    m_scl = 1'b0;     qwait();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; qwait();
    m_scl = 1'b1;     qwait();
    m_sda_low = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; qwait();
      m_scl = 1'b1; qwait(); qwait();
      m_scl = 1'b0;
    end
    m_sda_low = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    acked = ~sda_line; qwait();
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      b[i] = sda_line; qwait();
      m_scl = 1'b0;
    end
    m_sda_low = ack; qwait();
    m_scl = 1'b1; qwait(); qwait();
    m_scl = 1'b0; qwait();
    m_sda_low = 1'b0;
  endtask

  // Sets the pointer, then restarts into a read of n bytes (last one NACKed).
  task automatic read_at(input logic [7:0] p, input int n, input string req,
                         input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2, input logic [7:0] e3);
    logic ak;
    logic [7:0] d;
    logic [7:0] exp_b [4];
    exp_b[0] = e0; exp_b[1] = e1; exp_b[2] = e2; exp_b[3] = e3;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(p, ak);
    chk({req, " R4 pointer ack"}, ak, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    chk({req, " R10 restart read ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(req, d, exp_b[k]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe low", sda_oe, 0);
    chk("R1 reg_we low", reg_we, 0);
  endtask

  task automatic t_read_no_addr();
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    chk("R2 read address ack", ak, 1);
    recv_byte(1'b0, d);
    chk("R1 R6 first read from 0x00", d, init_val(8'h00));
    bus_stop();
  endtask

  task automatic t_write_single();
    logic ak;
    int w0 = we_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    chk("R2 write address ack", ak, 1);
    send_byte(8'h10, ak);
    chk("R4 pointer byte ack", ak, 1);
    send_byte(8'h3C, ak);
    chk("R5 data byte ack", ak, 1);
    bus_stop();
    chk("R5 one strobe", we_cnt - w0, 1);
  endtask

  task automatic t_write_burst();
    logic ak;
    int w0 = we_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h20, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak);
    bus_stop();
    chk("R5 burst strobes", we_cnt - w0, 3);
  endtask

  task automatic t_continue_after_nack();
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, ak);
    recv_byte(1'b0, d);
    chk("R7 R9 read resumes after NACK", d, init_val(8'h12));
  endtask

  task automatic t_mismatch();
    logic ak;
    int w0 = we_cnt;
    int o0 = oe_cnt;
    bus_stop();
    bus_start();
    send_byte({OTHER, 1'b0}, ak);
    chk("R3 mismatch NACK", ak, 0);
    send_byte(8'h40, ak);
    send_byte(8'h99, ak);
    bus_stop();
    chk("R3 no SDA drive", oe_cnt - o0, 0);
    chk("R3 no writes", we_cnt - w0, 0);
    read_at(8'h40, 1, "R3 register untouched", init_val(8'h40), 8'h0, 8'h0, 8'h0);
  endtask

  task automatic t_wrap();
    logic ak;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'hFE, ak);
    send_byte(8'hA1, ak);
    send_byte(8'hB2, ak);
    send_byte(8'hC3, ak);
    bus_stop();
    read_at(8'hFE, 4, "R8 wrap", 8'hA1, 8'hB2, 8'hC3, init_val(8'h01));
  endtask

  task automatic t_standard_rate();
    logic ak;
    q_cyc = 125;
    bus_start();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h50, ak);
    send_byte(8'h81, ak);
    chk("R11 100k data ack", ak, 1);
    bus_stop();
    read_at(8'h50, 2, "R11 100k readback", 8'h81, init_val(8'h51), 8'h0, 8'h0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read_no_addr();
    t_write_single();
    t_write_burst();
    read_at(8'h0F, 3, "R6 R7 R10 restart burst", init_val(8'h0F), 8'h3C, init_val(8'h11), 8'h0);
    t_continue_after_nack();
    read_at(8'h20, 3, "R5 R6 burst readback", 8'h11, 8'h22, 8'h33, 8'h0);
    t_mismatch();
    t_wrap();
    t_standard_rate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule